// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the read-path status of a byte-wide parallel flash device while an embedded program or erase is running. An upstream command decoder, outside this block, handles the unlock cycles. After the final command cycle of a byte program, sector erase or chip erase, it raises a one-cycle start pulse. The pulse carries the operation type, the protection state of the target, and the byte being programmed. The block then holds a busy timer. For as long as the timer runs, the data-out bus carries status bits in place of array data.

Bit 7 is a polling bit. Its busy value depends on the operation type, and it settles to the true array bit once the operation is over. Bit 6 inverts on each new read access, and a host can watch it stop toggling to detect completion. Chip enable and output enable are active-low strobes sampled on the block clock. A read access is the clock cycle in which both strobes first become low together.

Operations that target protected storage still show busy status, but only for a short fixed window, after which the array data is returned unchanged. A read that is still in progress when the operation finishes shows the final bit 7 with the lower bits held at zero. Clean data appears from the next read access onward.

Top module: `flash_status_gen`

## Requirements
- R1: While rst_ni is low and after reset, busy_o is 0 and dq_o equals array_data_i.
- R2: While busy with a byte program (op code 2'b01), dq_o[7] is the inverse of bit 7 of the byte latched at start and dq_o[5:0] are 0.
- R3: While busy with a sector erase (op code 2'b10) or a chip erase (op code 2'b11), dq_o[7] is 0.
- R4: While busy, dq_o[6] starts at 0 and inverts once for each read access, where a read access is a cycle in which ce_ni and oe_ni are both low and were not both low in the previous cycle; holding both low does not invert it again.
- R5: A read access produced by pulsing ce_ni with oe_ni held low inverts dq_o[6] the same way as one produced by pulsing oe_ni.
- R6: An accepted start raises busy_o from the next cycle, for exactly PROG_CYC, SERASE_CYC or CERASE_CYC cycles for program, sector erase or chip erase on an unprotected target.
- R7: With prot_i high at start, busy lasts CLK_MHZ*2 cycles (about 2 us) for a program and CLK_MHZ*100 cycles (about 100 us) for either erase, and the status encoding is the same as for R2 and R3.
- R8: When not busy and no completion read is pending, dq_o equals array_data_i, and read accesses change nothing.
- R9: A start pulse that arrives while busy is ignored: the duration and the operation type in progress are unchanged.
- R10: If both strobes are low in the final busy cycle, then from completion until the next read access dq_o is {array_data_i[7], 7'b0}, and after that access dq_o equals array_data_i.
- R11: A start pulse with op code 2'b00 is ignored and busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable strobe, active low, synchronous |
| oe_ni | input | 1 | Output enable strobe, active low, synchronous |
| start_i | input | 1 | One-cycle pulse when an embedded operation begins |
| op_type_i | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 none |
| prot_i | input | 1 | Target sector(s) protected, sampled with start_i |
| prog_data_i | input | 8 | Byte being programmed, sampled with start_i |
| array_data_i | input | 8 | Array read data from the storage path |
| dq_o | output | 8 | Read data or status |
| busy_o | output | 1 | Embedded operation in progress |

## Verification
A wrong busy count is visible at the first cycle after the expected end. At that point the bench still sees busy_o high, or sees array data one cycle early, so the error shows up exactly at the boundary. A toggle flop that misses or double-counts an access makes dq_o[6] disagree with the parity of accesses on the very next sample. A stuck completion-read flag, or one that clears too early, shows up either as zeroed low bits on an idle read or as full data before a fresh access. A latched program byte that is wrong or changes flips dq_o[7] in the first busy cycle, and the sweep over every byte value covers this.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_SECT = 2'b10,
    OP_CHIP = 2'b11
  } op_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fsp_access_det.sv
module fsp_access_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic oe_ni,
  output logic rd_low_o,
  output logic access_o
);
  logic rd_q;

  assign rd_low_o = ~ce_ni & ~oe_ni;
  // new access on entry into the combined-low condition
  assign access_o = rd_low_o & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= 1'b0;
    else         rd_q <= rd_low_o;
  end
endmodule

// File: rtl/fsp_busy_timer.sv
module fsp_busy_timer
  import fsp_pkg::*;
#(
  parameter int CNT_W          = 9,
  parameter int PROG_CYC       = 12,
  parameter int SERASE_CYC     = 40,
  parameter int CERASE_CYC     = 80,
  parameter int PROT_PROG_CYC  = 8,
  parameter int PROT_ERASE_CYC = 400
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  op_e              op_i,
  input  logic             prot_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output op_e              op_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] dur;
  op_e              op_q;

  always_comb begin
    unique case (op_i)
      OP_PROG: dur = prot_i ? CNT_W'(PROT_PROG_CYC)  : CNT_W'(PROG_CYC);
      OP_SECT: dur = prot_i ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(SERASE_CYC);
      OP_CHIP: dur = prot_i ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(CERASE_CYC);
      default: dur = '0;
    endcase
  end

  assign busy_o   = (cnt_q != '0);
  assign last_o   = (cnt_q == CNT_W'(1));
  assign accept_o = start_i & ~busy_o & (op_i != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= OP_NONE;
    end else if (accept_o) begin
      cnt_q <= dur;
      op_q  <= op_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign op_o  = op_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/fsp_status_mux.sv
module fsp_status_mux
  import fsp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       prog_bit7_i,
  input  logic       busy_i,
  input  logic       last_i,
  input  logic       access_i,
  input  logic       rd_low_i,
  input  op_e        op_i,
  input  logic [7:0] array_data_i,
  output logic       stale_o,
  output logic [7:0] dq_o
);
  logic prog7_q;
  logic tgl_q;
  logic stale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog7_q <= 1'b0;
      tgl_q   <= 1'b0;
      stale_q <= 1'b0;
    end else if (accept_i) begin
      prog7_q <= prog_bit7_i;
      tgl_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      if (busy_i && access_i) tgl_q <= ~tgl_q;
      // read spanning completion: low bits not yet valid
      if (last_i && rd_low_i)  stale_q <= 1'b1;
      else if (access_i)       stale_q <= 1'b0;
    end
  end

  always_comb begin
    if (busy_i)
      dq_o = {(op_i == OP_PROG) ? ~prog7_q : 1'b0, tgl_q, 6'b0};
    else if (stale_q)
      dq_o = {array_data_i[7], 7'b0};
    else
      dq_o = array_data_i;
  end

  assign stale_o = stale_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsp_pkg::*;
#(
  parameter int CLK_MHZ    = 4,
  parameter int PROG_CYC   = 12,
  parameter int SERASE_CYC = 40,
  parameter int CERASE_CYC = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_ni,
  input  logic       oe_ni,
  input  logic       start_i,
  input  logic [1:0] op_type_i,
  input  logic       prot_i,
  input  logic [7:0] prog_data_i,
  input  logic [7:0] array_data_i,
  output logic [7:0] dq_o,
  output logic       busy_o
);
  localparam int PROT_PROG_CYC  = CLK_MHZ * 2;
  localparam int PROT_ERASE_CYC = CLK_MHZ * 100;
  localparam int MAX_CYC = max2(max2(PROG_CYC, SERASE_CYC),
                                max2(CERASE_CYC, max2(PROT_PROG_CYC, PROT_ERASE_CYC)));
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  logic             rd_low;
  logic             access;
  logic             accept;
  logic             last;
  logic             stale_q;
  op_e              op_q;
  logic [CNT_W-1:0] cnt_q;

  fsp_access_det u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .rd_low_o (rd_low),
    .access_o (access)
  );

  fsp_busy_timer #(
    .CNT_W          (CNT_W),
    .PROG_CYC       (PROG_CYC),
    .SERASE_CYC     (SERASE_CYC),
    .CERASE_CYC     (CERASE_CYC),
    .PROT_PROG_CYC  (PROT_PROG_CYC),
    .PROT_ERASE_CYC (PROT_ERASE_CYC)
  ) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .op_i     (op_e'(op_type_i)),
    .prot_i   (prot_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .last_o   (last),
    .op_o     (op_q),
    .cnt_o    (cnt_q)
  );

  fsp_status_mux u_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .prog_bit7_i  (prog_data_i[7]),
    .busy_i       (busy_o),
    .last_i       (last),
    .access_i     (access),
    .rd_low_i     (rd_low),
    .op_i         (op_q),
    .array_data_i (array_data_i),
    .stale_o      (stale_q),
    .dq_o         (dq_o)
  );
endmodule

// File: rtl/fsp_status_chk.sv
module fsp_status_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [1:0]       op_type_i,
  input logic [7:0]       array_data_i,
  input logic [7:0]       dq_o,
  input logic             busy_o,
  input logic             access,
  input logic             stale_q,
  input logic [1:0]       op_q,
  input logic [CNT_W-1:0] cnt_q
);
  a_r1_reset_idle: assert property (@(posedge clk_i) $rose(rst_ni) |-> !busy_o);

  a_r6_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_type_i != 2'b00) |=> busy_o);

  a_r11_none_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && op_type_i == 2'b00) |=> !busy_o);

  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q > CNT_W'(1)) |=> (busy_o && $stable(op_q)));

  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (dq_o[5:0] == 6'b0));

  a_r3_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q != 2'b01) |-> !dq_o[7]);

  a_r4_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && access && cnt_q > CNT_W'(1)) |=> (dq_o[6] != $past(dq_o[6])));

  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !access && cnt_q > CNT_W'(1)) |=> $stable(dq_o[6]));

  a_r8_idle_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !stale_q) |-> (dq_o == array_data_i));

  a_r10_stale_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_q |-> (dq_o == {array_data_i[7], 7'b0}));
endmodule

bind flash_status_gen fsp_status_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .op_type_i    (op_type_i),
  .array_data_i (array_data_i),
  .dq_o         (dq_o),
  .busy_o       (busy_o),
  .access       (access),
  .stale_q      (stale_q),
  .op_q         (op_q),
  .cnt_q        (cnt_q)
);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ    = 4;
  localparam int PROG_CYC   = 12;
  localparam int SERASE_CYC = 40;
  localparam int CERASE_CYC = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic       prot = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic [7:0] arr = 8'h5A;
  logic [7:0] dq;
  logic       busy;

  int errors = 0;
  int checks = 0;
  int cyc_count = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(
    .CLK_MHZ(CLK_MHZ), .PROG_CYC(PROG_CYC),
    .SERASE_CYC(SERASE_CYC), .CERASE_CYC(CERASE_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n),
    .start_i(start), .op_type_i(op), .prot_i(prot),
    .prog_data_i(pdata), .array_data_i(arr), .dq_o(dq), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int dur(input logic [1:0] o, input logic p);
    if (o == 2'b01) return p ? CLK_MHZ * 2 : PROG_CYC;
    if (o == 2'b10) return p ? CLK_MHZ * 100 : SERASE_CYC;
    return p ? CLK_MHZ * 100 : CERASE_CYC;
  endfunction

  // drive a start pulse; returns at the first post-start negedge
  task automatic pulse_start(input logic [1:0] o, input logic p, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; op = o; prot = p; pdata = d;
    @(negedge clk);
    start = 1'b0; pdata = ~d;
  endtask

  // full operation with alternating reads; use_ce picks strobe (R5)
  task automatic run_op(input logic [1:0] o, input logic p, input logic [7:0] d,
                        input logic [7:0] a, input bit use_ce);
    int n = dur(o, p);
    int cyc = 0;
    bit exp_t = 1'b0;
    bit low = 1'b0;
    logic e7 = (o == 2'b01) ? ~d[7] : 1'b0;
    arr = a;
    if (use_ce) oe_n = 1'b0; else ce_n = 1'b0;
    pulse_start(o, p, d);
    while (busy && cyc < n + 4) begin
      cyc++;
      chk(dq[7] == e7, (o == 2'b01) ? "R2 poll bit" : "R3 erase poll", dq[7], e7);
      chk(dq[5:0] == 6'b0, "R2 low bits", dq[5:0], 0);
      if (low) begin
        exp_t = ~exp_t;
        chk(dq[6] == exp_t, use_ce ? "R5 ce toggle" : "R4 oe toggle", dq[6], exp_t);
        if (use_ce) ce_n = 1'b1; else oe_n = 1'b1;
        low = 1'b0;
      end else begin
        chk(dq[6] == exp_t, "R4 toggle held", dq[6], exp_t);
        if (cyc <= n - 2) begin
          if (use_ce) ce_n = 1'b0; else oe_n = 1'b0;
          low = 1'b1;
        end
      end
      @(negedge clk);
    end
    chk(cyc == n, p ? "R7 protected duration" : "R6 duration", cyc, n);
    chk(dq == a, "R8 data after completion", dq, a);
    // idle read changes nothing
    if (use_ce) ce_n = 1'b0; else oe_n = 1'b0;
    @(negedge clk);
    chk(dq == a && !busy, "R8 idle read", dq, a);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc_count++;
    if (cyc_count > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc_count);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(!busy && dq == 8'h5A, "R1 in reset", dq, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && dq == 8'h5A, "R1 after reset", dq, 8'h5A);

    // R2/R4/R6: program over every byte value
    for (int d = 0; d < 256; d++)
      run_op(2'b01, 1'b0, 8'(d), 8'(d ^ 8'h3C), d[0]);

    // R3/R6/R7: erases and protected windows
    for (int o = 1; o < 4; o++)
      for (int p = 0; p < 2; p++)
        run_op(2'(o), p[0], 8'hA5 ^ 8'(o), 8'hC3 ^ 8'(o << 2), p[0]);

    // R11: op code 00 ignored
    pulse_start(2'b00, 1'b0, 8'h80);
    chk(!busy && dq == arr, "R11 none ignored", busy, 0);
    @(negedge clk);
    chk(!busy, "R11 still idle", busy, 0);

    // R9: start during program ignored
    arr = 8'h11;
    pulse_start(2'b01, 1'b0, 8'h80);
    cyc = 0;
    while (busy && cyc < PROG_CYC + 4) begin
      cyc++;
      if (cyc == 3) begin start = 1'b1; op = 2'b11; prot = 1'b1; end
      else start = 1'b0;
      chk(dq[7] == 1'b0, "R9 poll kept as program", dq[7], 0);
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == PROG_CYC, "R9 duration unchanged", cyc, PROG_CYC);

    // R4: holding strobes low flips once only (chip erase)
    arr = 8'h7E;
    pulse_start(2'b11, 1'b0, 8'h00);
    oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    chk(dq[6] == 1'b1, "R4 first access", dq[6], 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dq[6] == 1'b1, "R4 held low no flip", dq[6], 1);
    end
    oe_n = 1'b1; ce_n = 1'b1;
    while (busy) @(negedge clk);
    chk(dq == 8'h7E, "R8 after hold test", dq, 8'h7E);

    // R10: read spanning completion
    arr = 8'hB6;
    pulse_start(2'b01, 1'b0, 8'h00);
    cyc = 1;
    while (cyc < PROG_CYC - 1) begin @(negedge clk); cyc++; end
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    chk(busy, "R10 still busy last cycle", busy, 1);
    @(negedge clk);
    chk(!busy && dq == 8'h80, "R10 partial data", dq, 8'h80);
    @(negedge clk);
    chk(dq == 8'h80, "R10 partial held", dq, 8'h80);
    oe_n = 1'b1;
    @(negedge clk);
    chk(dq == 8'h80, "R10 no access yet", dq, 8'h80);
    arr = 8'h36;
    @(negedge clk);
    chk(dq == 8'h00, "R10 tracks bit7", dq, 8'h00);
    oe_n = 1'b0;
    @(negedge clk);
    chk(dq == 8'h36, "R10 clean after access", dq, 8'h36);
    oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule